// File: doc/BRIEF.md
# Opcode-Driven Integer ALU

This block is the execute unit for a small 32-bit integer subset of a load/store RISC core. Each cycle it receives a complete instruction word and the two register values the instruction names (the first source and the second source). It decodes the instruction itself and computes the result for that instruction. The supported set covers:

- register-to-register add, subtract, AND, OR, NOR and signed compare;
- constant shifts of the second source, left, logical right and arithmetic right;
- immediate add, compare, AND, OR and upper-half load;
- the byte, halfword and word address computation that loads and stores share.

The surrounding pipeline reads the register file and handles the memory access and the writeback. A flag marks whether the word was a supported instruction. An unsupported word gives a flag of 0 and a result of zero.

The result and the flag pass through one output register. A parameter can remove this register to give a purely combinational path. With the default setting, the result for an instruction presented before a rising edge appears just after that edge.

Top module: `int_alu_decode`

## Requirements
- R1: While rst_ni is low, result_o and valid_o are held at 0, whatever the inputs are.
- R2: With opcode insn_i[31:26]=0x00, function insn_i[5:0]=0x20 gives rs_val_i + rt_val_i and 0x22 gives rs_val_i - rt_val_i, both modulo 2^32, with valid_o=1.
- R3: With opcode 0x00, function 0x24 gives the bitwise AND, 0x25 the bitwise OR and 0x27 the bitwise NOR of rs_val_i and rt_val_i.
- R4: With opcode 0x00, function 0x2a gives 1 when rs_val_i < rt_val_i as signed two's-complement values, and 0 otherwise. Bits 31..1 of the result are always 0.
- R5: With opcode 0x00, functions 0x00, 0x02 and 0x03 shift rt_val_i by the amount in insn_i[10:6] (0 to 31). 0x00 shifts left with zero fill, 0x02 shifts right with zero fill, and 0x03 shifts right, filling with bit 31.
- R6: Opcode 0x08 gives rs_val_i plus the sign-extended insn_i[15:0]. Opcode 0x0a gives 1 when rs_val_i is less than the sign-extended immediate as signed values, and 0 otherwise.
- R7: Opcode 0x0c gives rs_val_i AND the zero-extended immediate. Opcode 0x0d gives rs_val_i OR the zero-extended immediate.
- R8: Opcode 0x0f gives insn_i[15:0] in result bits 31..16, with bits 15..0 equal to zero.
- R9: Opcodes 0x20, 0x21, 0x23 (loads) and 0x28, 0x29, 0x2b (stores) give rs_val_i plus the sign-extended insn_i[15:0]. The function field has no effect on these opcodes.
- R10: Any other opcode, and any other function code under opcode 0x00, gives valid_o=0 and result_o=0.
- R11: With the default REG_OUT=1, outputs change only at a rising edge of clk_i and reflect the inputs present at that edge. The bits insn_i[25:11] never affect the result, except bits 15..11 where they form part of the immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of the first source register |
| rt_val_i | input | DATA_W | Value of the second source register |
| result_o | output | DATA_W | Computed result or address |
| valid_o | output | 1 | High when insn_i was a supported instruction |

## Verification
The same numeric code means different things depending on which field it sits in. Function 0x20 is an add under opcode 0x00, while opcode 0x20 is a load whose low six bits are displacement. The decode therefore has to give the opcode precedence.

The bench provokes these collisions directly. It issues loads and stores whose displacement ends in a function code that would be valid under opcode 0x00, such as 0x22 or 0x2a. It also places an unsupported word directly after a supported one. Each result is judged against a model that looks only at the opcode first. A compare, a shift or a zero result in place of the expected address exposes the faulty decode.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0a;
  localparam logic [5:0] OPC_ANDI = 6'h0c;
  localparam logic [5:0] OPC_ORI  = 6'h0d;
  localparam logic [5:0] OPC_LUI  = 6'h0f;
  localparam logic [5:0] OPC_LDB  = 6'h20;
  localparam logic [5:0] OPC_LDH  = 6'h21;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STB  = 6'h28;
  localparam logic [5:0] OPC_STH  = 6'h29;
  localparam logic [5:0] OPC_STW  = 6'h2b;

  localparam logic [5:0] FN_SHL  = 6'h00;
  localparam logic [5:0] FN_SHR  = 6'h02;
  localparam logic [5:0] FN_SHRA = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2a;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
    OP_SLT, OP_SHL, OP_SHR, OP_SHRA, OP_UPPER
  } alu_op_e;

  typedef enum logic [1:0] {
    B_REG, B_SEXT, B_ZEXT
  } b_src_e;
endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
  import alu_pkg::*;
(
  input  logic [5:0] opc_i,
  input  logic [5:0] fn_i,
  output alu_op_e    op_o,
  output b_src_e     b_src_o,
  output logic       legal_o
);
  alu_op_e op_d;
  b_src_e  src_d;
  logic    legal_d;

  always_comb begin
    op_d    = OP_NONE;
    src_d   = B_REG;
    legal_d = 1'b1;
    case (opc_i)
      OPC_REG: begin
        case (fn_i)
          FN_ADD:  op_d = OP_ADD;
          FN_SUB:  op_d = OP_SUB;
          FN_AND:  op_d = OP_AND;
          FN_OR:   op_d = OP_OR;
          FN_NOR:  op_d = OP_NOR;
          FN_SLT:  op_d = OP_SLT;
          FN_SHL:  op_d = OP_SHL;
          FN_SHR:  op_d = OP_SHR;
          FN_SHRA: op_d = OP_SHRA;
          default: legal_d = 1'b0;
        endcase
      end
      OPC_ADDI: begin op_d = OP_ADD;   src_d = B_SEXT; end
      OPC_SLTI: begin op_d = OP_SLT;   src_d = B_SEXT; end
      OPC_ANDI: begin op_d = OP_AND;   src_d = B_ZEXT; end
      OPC_ORI:  begin op_d = OP_OR;    src_d = B_ZEXT; end
      OPC_LUI:  begin op_d = OP_UPPER; src_d = B_ZEXT; end
      // memory forms: address only, opcode wins over the low bits
      OPC_LDB, OPC_LDH, OPC_LDW,
      OPC_STB, OPC_STH, OPC_STW: begin op_d = OP_ADD; src_d = B_SEXT; end
      default: legal_d = 1'b0;
    endcase
    if (!legal_d) op_d = OP_NONE;
  end

  assign op_o    = op_d;
  assign b_src_o = src_d;
  assign legal_o = legal_d;
endmodule

// File: rtl/alu_operand.sv
module alu_operand
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned EXT_W = DATA_W - IMM_W
) (
  input  b_src_e            sel_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] b_o
);
  always_comb begin
    case (sel_i)
      B_SEXT:  b_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      B_ZEXT:  b_o = {{EXT_W{1'b0}}, imm_i};
      default: b_o = reg_i;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] pre, post;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  // left shift done as right shift of the bit-reversed value
  always_comb begin
    for (int i = 0; i < W; i++) pre[i] = left_i ? val_i[W-1-i] : val_i[i];
  end

  assign fill   = arith_i & ~left_i & val_i[W-1];
  assign stg[0] = pre;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) post[i] = left_i ? stg[SW][W-1-i] : stg[SW][i];
  end

  assign res_o = post;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SW = $clog2(DATA_W),
  localparam int unsigned LOW_W = DATA_W - IMM_W
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SW-1:0]     sa_i,
  output logic [DATA_W-1:0] res_o
);
  logic              inv_b;
  logic [DATA_W-1:0] b_x, sum, sh_res;
  logic              lt_s;

  // one adder serves add, subtract and both compares
  assign inv_b = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign b_x   = inv_b ? ~b_i : b_i;
  assign sum   = a_i + b_x + {{(DATA_W-1){1'b0}}, inv_b};
  assign lt_s  = (a_i[DATA_W-1] ^ b_i[DATA_W-1]) ? a_i[DATA_W-1] : sum[DATA_W-1];

  alu_shifter #(.W(DATA_W)) u_shift (
    .val_i   (b_i),
    .amt_i   (sa_i),
    .left_i  (op_i == OP_SHL),
    .arith_i (op_i == OP_SHRA),
    .res_o   (sh_res)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB:         res_o = sum;
      OP_AND:                 res_o = a_i & b_i;
      OP_OR:                  res_o = a_i | b_i;
      OP_NOR:                 res_o = ~(a_i | b_i);
      OP_SLT:                 res_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SHL, OP_SHR, OP_SHRA: res_o = sh_res;
      OP_UPPER:               res_o = {b_i[IMM_W-1:0], {LOW_W{1'b0}}};
      default:                res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned SW = $clog2(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INSN_W-1:0]   insn_i,
  input  logic [DATA_W-1:0]   rs_val_i,
  input  logic [DATA_W-1:0]   rt_val_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                valid_o
);
  alu_op_e           op;
  b_src_e            b_src;
  logic              legal;
  logic [DATA_W-1:0] opnd_b, res_d;

  alu_decoder u_dec (
    .opc_i   (insn_i[31:26]),
    .fn_i    (insn_i[5:0]),
    .op_o    (op),
    .b_src_o (b_src),
    .legal_o (legal)
  );

  alu_operand #(.DATA_W(DATA_W)) u_opnd (
    .sel_i (b_src),
    .reg_i (rt_val_i),
    .imm_i (insn_i[IMM_W-1:0]),
    .b_o   (opnd_b)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i  (op),
    .a_i   (rs_val_i),
    .b_i   (opnd_b),
    .sa_i  (insn_i[6 +: SW]),
    .res_o (res_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o <= '0;
        valid_o  <= 1'b0;
      end else begin
        result_o <= res_d;
        valid_o  <= legal;
      end
    end
  end else begin : g_comb
    assign result_o = rst_ni ? res_d : '0;
    assign valid_o  = rst_ni & legal;
  end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        opc_i,
  input logic [5:0]        fn_i,
  input logic [4:0]        sa_i,
  input logic [15:0]       imm_i,
  input logic              rt_msb_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_invalid_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> result_o == '0);

  p_upper_place_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h0f |-> valid_o && result_o == {$past(imm_i), 16'h0000});

  p_cmp_bool_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h00 && $past(fn_i) == 6'h2a |-> valid_o && result_o[DATA_W-1:1] == '0);

  p_shl_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h00 && $past(fn_i) == 6'h00
    |-> (result_o & ~({DATA_W{1'b1}} << $past(sa_i))) == '0);

  p_shra_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h00 && $past(fn_i) == 6'h03 |-> result_o[DATA_W-1] == $past(rt_msb_i));

  p_shr_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h00 && $past(fn_i) == 6'h02 && $past(sa_i) != 5'd0
    |-> !result_o[DATA_W-1]);

  p_zext_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(opc_i) == 6'h0c |-> valid_o && result_o[DATA_W-1:16] == '0);
endmodule

bind int_alu_decode alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opc_i    (insn_i[31:26]),
  .fn_i     (insn_i[5:0]),
  .sa_i     (insn_i[10:6]),
  .imm_i    (insn_i[15:0]),
  .rt_msb_i (rt_val_i[DATA_W-1]),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/sim_int_alu_decode.sv
module sim_int_alu_decode;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn = '0, rs_v = '0, rt_v = '0;
  logic [31:0] result;
  logic        valid;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [31:0] res;
    logic        vld;
    string       req;
  } exp_t;
  exp_t q[$];

  int_alu_decode u0 (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn),
    .rs_val_i(rs_v), .rt_val_i(rt_v), .result_o(result), .valid_o(valid)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act_r, logic act_v, logic [31:0] exp_r, logic exp_v);
    n_chk++;
    if (act_r !== exp_r || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b", req, act_r, act_v, exp_r, exp_v);
    end
  endtask

  function automatic logic [32:0] model(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [31:0] se, ze;
    logic [4:0]  sa;
    se = {{16{w[15]}}, w[15:0]};
    ze = {16'h0, w[15:0]};
    sa = w[10:6];
    case (w[31:26])
      6'h00: case (w[5:0])
        6'h20: return {1'b1, a + b};
        6'h22: return {1'b1, a - b};
        6'h24: return {1'b1, a & b};
        6'h25: return {1'b1, a | b};
        6'h27: return {1'b1, ~(a | b)};
        6'h2a: return {1'b1, 31'd0, $signed(a) < $signed(b)};
        6'h00: return {1'b1, b << sa};
        6'h02: return {1'b1, b >> sa};
        6'h03: return {1'b1, 32'($signed(b) >>> sa)};
        default: return 33'd0;
      endcase
      6'h08: return {1'b1, a + se};
      6'h0a: return {1'b1, 31'd0, $signed(a) < $signed(se)};
      6'h0c: return {1'b1, a & ze};
      6'h0d: return {1'b1, a | ze};
      6'h0f: return {1'b1, w[15:0], 16'h0};
      6'h20, 6'h21, 6'h23, 6'h28, 6'h29, 6'h2b: return {1'b1, a + se};
      default: return 33'd0;
    endcase
  endfunction

  function automatic string req_of(logic [31:0] w);
    case (w[31:26])
      6'h00: case (w[5:0])
        6'h20, 6'h22: return "R2";
        6'h24, 6'h25, 6'h27: return "R3";
        6'h2a: return "R4";
        6'h00, 6'h02, 6'h03: return "R5";
        default: return "R10";
      endcase
      6'h08, 6'h0a: return "R6";
      6'h0c, 6'h0d: return "R7";
      6'h0f: return "R8";
      6'h20, 6'h21, 6'h23, 6'h28, 6'h29, 6'h2b: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] pick(int k);
    case (k % 7)
      0: return 32'h8000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'hffff_ffff;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [32:0] m;
    exp_t e;
    @(negedge clk);
    insn = w; rs_v = a; rt_v = b;
    m = model(w, a, b);
    e.res = m[31:0]; e.vld = m[32]; e.req = req_of(w);
    q.push_back(e);
  endtask

  // monitor: result for a word driven at a falling edge is due after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, result, valid, e.res, e.vld);
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: result=%h valid=%b expected completion", result, valid);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [5:0] REG_FN [9] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2a, 6'h00, 6'h02, 6'h03};
  localparam logic [5:0] IMM_OP [11] = '{6'h08, 6'h0a, 6'h0c, 6'h0d, 6'h0f,
                                         6'h20, 6'h21, 6'h23, 6'h28, 6'h29, 6'h2b};

  initial begin
    // R1: reset holds outputs low even with a live add on the inputs
    insn = 32'h0000_0020; rs_v = 32'h1234; rt_v = 32'h1;
    repeat (3) @(posedge clk);
    #5 check("R1", result, valid, 32'h0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;

    // register forms, corner operands and shift amounts 0 and 31
    foreach (REG_FN[f]) begin
      for (int k = 0; k < 24; k++) begin
        logic [4:0] sa;
        sa = (k % 3 == 0) ? 5'd31 : (k % 3 == 1) ? 5'd0 : 5'($urandom);
        issue({6'h00, 5'($urandom), 5'($urandom), 5'($urandom), sa, REG_FN[f]},
              pick(k), pick(k + 3));
      end
    end

    // immediate forms, with immediates that flip the sign-extension
    foreach (IMM_OP[o]) begin
      for (int k = 0; k < 24; k++) begin
        logic [15:0] imm;
        case (k % 4)
          0: imm = 16'h8000;
          1: imm = 16'h7fff;
          2: imm = 16'hffff;
          default: imm = 16'($urandom);
        endcase
        issue({IMM_OP[o], 5'($urandom), 5'($urandom), imm}, pick(k), pick(k + 1));
      end
    end

    // R9: displacement low bits look like register-form function codes
    issue({6'h23, 10'h3ff, 16'hffe2}, 32'h0000_0100, 32'hdead_beef);
    issue({6'h28, 10'h000, 16'h002a}, 32'h7fff_fff0, 32'h1);
    issue({6'h20, 10'h155, 16'h0020}, 32'h8000_0000, 32'h5);

    // R10: unsupported words, back to back with supported ones
    issue({6'h00, 20'h12345, 6'h21}, 32'h5, 32'h7);
    issue({6'h00, 20'h0, 6'h20}, 32'h5, 32'h7);
    issue({6'h04, 26'h3ff_ffff}, 32'hffff_ffff, 32'hffff_ffff);
    issue({6'h22, 26'h0000_010}, 32'h40, 32'h0);
    issue({6'h3f, 26'h0}, 32'h1, 32'h1);
    issue({6'h0f, 10'h0, 16'hffff}, 32'h0, 32'h0);

    // R11: output waits for the edge; unused fields change nothing
    issue({6'h00, 5'd0, 5'd0, 5'd0, 5'd0, 6'h22}, 32'h10, 32'h3);
    @(posedge clk); #6;
    @(negedge clk);
    insn = {6'h00, 5'd31, 5'd31, 5'd31, 5'd0, 6'h20}; rs_v = 32'h10; rt_v = 32'h3;
    #2 check("R11", result, valid, 32'hd, 1'b1);
    @(posedge clk); #5 check("R11", result, valid, 32'h13, 1'b1);

    repeat (3) @(posedge clk);
    #7;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule